// File: doc/BRIEF.md
# Link and Activity LED Controller

This block turns the link state of an Ethernet port into three LED pin levels. A 16-bit select word gives each LED a 4-bit field. Three bits of that field choose the link speeds (10, 100, 1000 Mb/s) at which the LED lights. The fourth bit makes the LED blink while traffic is present. The top nibble is feature control and has no effect on the pins. LEDs are active low, so a lit LED drives 0.

An 8-bit blink-timing word sets the period and on-fraction of the blink. Time is counted from a microsecond tick derived from the clock. A single activity pulse is stretched to cover one whole blink period. An all-zero select word releases every pin (output enable low) to save power. A power-down flag forces every LED pin high. The LED1 pin can instead act as a plain general-purpose output. All pin values are registered.

Top module: `led_status_ctrl`

## Requirements
- R1: The select word carries LED0 in bits 3:0, LED1 in bits 7:4 and LED2 in bits 11:8. In each field, bit 0 lights the LED at 10M, bit 1 at 100M and bit 2 at 1000M. The speed code is 00=10M, 01=100M, 10=1000M and 11=no speed. A lit LED drives its pin to 0, and an unlit LED drives it to 1.
- R2: When the link is down or the speed code is 11, every LED pin that is driven is unlit (1).
- R3: Bit 3 of a field enables blinking. While activity is active, a lit LED with that bit set is driven unlit during the off portion of each blink period. Without activity, or with bit 3 clear, a lit LED stays steadily lit.
- R4: When all 16 select bits are zero and power-down is low, every LED output enable is 0 and the pin value is 1. A non-zero feature nibble (bits 15:12) alone keeps the pins driven and unlit.
- R5: Power-down drives every LED pin to 1 with its output enable at 1. It overrides R1 to R4.
- R6: The blink period is 5*(T[3:0]+5) ms. The duty code T[5:4] gives an on-fraction of 6/8, 4/8, 2/8 or 7/8 for codes 0, 1, 2 and 3. The on portion is the set of whole milliseconds m in 0..P-1 with 8m < on*P. T[7:6] has no effect. Code 0x0B gives 80 ms at 75%.
- R7: One activity pulse, however short, makes activity active for exactly one full blink period, starting at the next period boundary.
- R8: When the pin-1 mode bit is set, pin 1 drives the general-purpose level with its output enable at 1, regardless of the other inputs. When the bit is clear, pin 1 is LED1.
- R9: Each output reflects its inputs one clock cycle after they are sampled. Reset gives all pins 1 with output enables at 0.
- R10: One millisecond is CLKS_PER_US*US_PER_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Speed code (00 10M, 01 100M, 10 1000M, 11 none) |
| act_pulse | input | 1 | TX/RX activity pulse |
| pwr_down | input | 1 | Power-down flag |
| led_sel | input | 16 | LED select word |
| blink_cfg | input | 8 | Blink timing word |
| pin1_gpo_mode | input | 1 | Pin 1 acts as general-purpose output |
| pin1_gpo_level | input | 1 | Level for pin 1 in general-purpose mode |
| led_out | output | 3 | Pin levels, index = LED number |
| led_oe | output | 3 | Pin output enables |

## Verification
The hardest case to reach is a single activity pulse that lands at an arbitrary point of a free-running blink period. The design must show exactly one off window of the right length, and never a clipped one. The bench first lets any earlier activity drain for several periods. It then issues one pulse and counts the unlit cycles over three periods, expecting exactly one off window. Period and duty are measured between consecutive lit-to-unlit edges while activity is held on. A shortened microsecond and millisecond scale keeps these periods to a few hundred cycles.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    localparam int LED_COUNT  = 3;
    localparam int NIB_W      = 4;
    localparam int SEL_W      = (LED_COUNT + 1) * NIB_W;
    localparam int CFG_W      = 8;
    localparam int STEP_MS    = 5;
    localparam int BASE_STEPS = 5;
    localparam int PH_W       = 7;
    localparam int CMP_W      = 12;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_NONE = 2'd3
    } speed_e;

    typedef struct packed {
        logic       blink_en;
        logic [2:0] speed_mask;
    } led_nib_t;

    typedef struct packed {
        logic [1:0] unused;
        logic [1:0] duty;
        logic [3:0] period;
    } blink_cfg_t;

    typedef struct packed {
        logic active;
        logic phase_on;
    } blink_state_t;

    function automatic logic [PH_W-1:0] period_ms(input logic [3:0] code);
        return PH_W'(STEP_MS * (int'(code) + BASE_STEPS));
    endfunction

    function automatic logic [3:0] on_eighths(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd6;
            2'd1:    return 4'd4;
            2'd2:    return 4'd2;
            default: return 4'd7;
        endcase
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int CLKS_PER_US = 200,
    parameter int US_PER_MS   = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic ms_tick
);
    localparam int US_W = $clog2(CLKS_PER_US + 1);
    localparam int MS_W = $clog2(US_PER_MS + 1);

    logic [US_W-1:0] us_cnt;
    logic [MS_W-1:0] ms_cnt;
    logic            us_tick;

    assign us_tick = (us_cnt == US_W'(CLKS_PER_US - 1));
    assign ms_tick = us_tick && (ms_cnt == MS_W'(US_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            us_cnt <= '0;
            ms_cnt <= '0;
        end else begin
            us_cnt <= us_tick ? '0 : us_cnt + 1'b1;
            if (us_tick) begin
                ms_cnt <= ms_tick ? '0 : ms_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
    import led_status_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ms_tick,
    input  blink_cfg_t   cfg,
    input  logic         act_pulse,
    output blink_state_t state
);
    logic [PH_W-1:0]  ph_cnt;
    logic [PH_W-1:0]  period;
    logic             wrap;
    logic             pending;
    logic             active;
    logic [CMP_W-1:0] pos_scaled;
    logic [CMP_W-1:0] on_limit;

    assign period     = period_ms(cfg.period);
    assign wrap       = ms_tick && (ph_cnt >= period - 1'b1);
    assign pos_scaled = CMP_W'({ph_cnt, 3'b000});
    assign on_limit   = CMP_W'(on_eighths(cfg.duty)) * CMP_W'(period);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_cnt  <= '0;
            pending <= 1'b0;
            active  <= 1'b0;
        end else begin
            if (ms_tick) begin
                ph_cnt <= wrap ? '0 : ph_cnt + 1'b1;
            end
            if (wrap) begin
                active  <= pending | act_pulse;
                pending <= 1'b0;
            end else begin
                pending <= pending | act_pulse;
            end
        end
    end

    assign state.active   = active;
    assign state.phase_on = (pos_scaled < on_limit);
endmodule

// File: rtl/led_lane.sv
module led_lane
    import led_status_pkg::*;
(
    input  led_nib_t     nib,
    input  logic         link_up,
    input  speed_e       speed,
    input  blink_state_t blink,
    output logic         lit
);
    logic hit;
    logic dark_phase;

    always_comb begin
        hit = 1'b0;
        if (link_up && speed != SPD_NONE) begin
            hit = nib.speed_mask[speed];
        end
    end

    assign dark_phase = nib.blink_en && blink.active && !blink.phase_on;
    assign lit        = hit && !dark_phase;
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
    import led_status_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int US_PER_MS   = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 link_up,
    input  logic [1:0]           link_speed,
    input  logic                 act_pulse,
    input  logic                 pwr_down,
    input  logic [SEL_W-1:0]     led_sel,
    input  logic [CFG_W-1:0]     blink_cfg,
    input  logic                 pin1_gpo_mode,
    input  logic                 pin1_gpo_level,
    output logic [LED_COUNT-1:0] led_out,
    output logic [LED_COUNT-1:0] led_oe
);
    localparam int GPO_PIN = 1;

    logic                 ms_tick;
    blink_state_t         blink;
    logic [LED_COUNT-1:0] lit;
    logic [LED_COUNT-1:0] nxt_out;
    logic [LED_COUNT-1:0] nxt_oe;
    logic                 all_off;

    led_tick_gen #(
        .CLKS_PER_US(CLKS_PER_US),
        .US_PER_MS  (US_PER_MS)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .ms_tick(ms_tick)
    );

    led_blink_gen u_blink (
        .clk      (clk),
        .rst      (rst),
        .ms_tick  (ms_tick),
        .cfg      (blink_cfg_t'(blink_cfg)),
        .act_pulse(act_pulse),
        .state    (blink)
    );

    for (genvar i = 0; i < LED_COUNT; i++) begin : g_lane
        led_lane u_lane (
            .nib    (led_nib_t'(led_sel[i*NIB_W +: NIB_W])),
            .link_up(link_up),
            .speed  (speed_e'(link_speed)),
            .blink  (blink),
            .lit    (lit[i])
        );
    end

    assign all_off = (led_sel == '0);

    always_comb begin
        for (int i = 0; i < LED_COUNT; i++) begin
            if (pwr_down) begin
                nxt_out[i] = 1'b1;
                nxt_oe[i]  = 1'b1;
            end else if (all_off) begin
                nxt_out[i] = 1'b1;
                nxt_oe[i]  = 1'b0;
            end else begin
                nxt_out[i] = !lit[i];
                nxt_oe[i]  = 1'b1;
            end
        end
        if (pin1_gpo_mode) begin
            nxt_out[GPO_PIN] = pin1_gpo_level;
            nxt_oe[GPO_PIN]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_out <= '1;
            led_oe  <= '0;
        end else begin
            led_out <= nxt_out;
            led_oe  <= nxt_oe;
        end
    end
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        link_up,
    input logic        pwr_down,
    input logic [15:0] led_sel,
    input logic        pin1_gpo_mode,
    input logic        pin1_gpo_level,
    input logic [2:0]  led_out,
    input logic [2:0]  led_oe
);
    a_r5_pd_high: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (led_out[0] && led_out[2] && led_oe[0] && led_oe[2]));

    a_r4_float: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && led_sel == 16'h0) |=> (!led_oe[0] && !led_oe[2]));

    a_r8_gpo: assert property (@(posedge clk) disable iff (rst)
        pin1_gpo_mode |=> (led_oe[1] && led_out[1] == $past(pin1_gpo_level)));

    a_r2_dark: assert property (@(posedge clk) disable iff (rst)
        (!link_up && !pin1_gpo_mode) |=> (led_out == 3'b111));
endmodule

bind led_status_ctrl led_status_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .link_up       (link_up),
    .pwr_down      (pwr_down),
    .led_sel       (led_sel),
    .pin1_gpo_mode (pin1_gpo_mode),
    .pin1_gpo_level(pin1_gpo_level),
    .led_out       (led_out),
    .led_oe        (led_oe)
);

// File: tb/led_status_ctrl_tb.sv
`timescale 1ns/1ps
module led_status_ctrl_tb;
    localparam int CPU = 2;
    localparam int UPM = 2;
    localparam int CYC_PER_MS = CPU * UPM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = 2'd0;
    logic        act_pulse = 1'b0;
    logic        pwr_down = 1'b0;
    logic [15:0] led_sel = 16'h0CA9;
    logic [7:0]  blink_cfg = 8'h0B;
    logic        pin1_gpo_mode = 1'b0;
    logic        pin1_gpo_level = 1'b0;
    logic [2:0]  led_out;
    logic [2:0]  led_oe;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    led_status_ctrl #(.CLKS_PER_US(CPU), .US_PER_MS(UPM)) u_dut (
        .clk(clk), .rst(rst), .link_up(link_up), .link_speed(link_speed),
        .act_pulse(act_pulse), .pwr_down(pwr_down), .led_sel(led_sel),
        .blink_cfg(blink_cfg), .pin1_gpo_mode(pin1_gpo_mode),
        .pin1_gpo_level(pin1_gpo_level), .led_out(led_out), .led_oe(led_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int exp_period(input logic [7:0] c);
        return 5 * (int'(c[3:0]) + 5);
    endfunction

    function automatic int exp_on_ms(input logic [7:0] c);
        int on8;
        int p;
        int n;
        p = exp_period(c);
        case (c[5:4])
            2'd0: on8 = 6;
            2'd1: on8 = 4;
            2'd2: on8 = 2;
            default: on8 = 7;
        endcase
        n = 0;
        for (int m = 0; m < p; m++) if (8 * m < on8 * p) n++;
        return n;
    endfunction

    task automatic measure(output int per, output int lowc);
        logic prev;
        int guard;
        per = 0;
        lowc = 0;
        prev = led_out[0];
        guard = 0;
        while (guard < 2000) begin
            @(negedge clk);
            guard++;
            if (!prev && led_out[0]) break;
            prev = led_out[0];
        end
        prev = 1'b1;
        guard = 0;
        while (guard < 2000) begin
            @(negedge clk);
            guard++;
            per++;
            if (!led_out[0]) lowc++;
            if (!prev && led_out[0]) break;
            prev = led_out[0];
        end
    endtask

    task automatic t_reset;
        chk("R9 reset out", int'(led_out), 7);
        chk("R9 reset oe", int'(led_oe), 0);
    endtask

    task automatic t_speed;
        led_sel = 16'h0CA9; link_up = 1'b1; act_pulse = 1'b0;
        link_speed = 2'd0; step(1);
        chk("R1 10M", int'(led_out), 6);
        chk("R1 oe driven", int'(led_oe), 7);
        link_speed = 2'd1; step(1);
        chk("R1 100M", int'(led_out), 5);
        link_speed = 2'd2; step(1);
        chk("R1 1000M", int'(led_out), 3);
        led_sel = 16'h0327; step(1);
        chk("R1 mixed masks 1000M", int'(led_out), 6);
        link_speed = 2'd1; step(1);
        chk("R1 mixed masks 100M", int'(led_out), 0);
        link_speed = 2'd3; step(1);
        chk("R2 speed none", int'(led_out), 7);
        link_speed = 2'd0; link_up = 1'b0; step(1);
        chk("R2 link down", int'(led_out), 7);
        link_up = 1'b1; step(1);
        chk("R9 one cycle latency", int'(led_out), 2);
    endtask

    task automatic t_off_and_pd;
        led_sel = 16'h0000; step(1);
        chk("R4 all zero oe", int'(led_oe), 0);
        chk("R4 all zero out", int'(led_out), 7);
        led_sel = 16'hF000; step(1);
        chk("R4 feature nibble only oe", int'(led_oe), 7);
        chk("R4 feature nibble only out", int'(led_out), 7);
        led_sel = 16'h0CA9; pwr_down = 1'b1; step(1);
        chk("R5 power-down out", int'(led_out), 7);
        chk("R5 power-down oe", int'(led_oe), 7);
        led_sel = 16'h0000; step(1);
        chk("R5 power-down over all-off", int'(led_oe), 7);
        pwr_down = 1'b0; led_sel = 16'h0CA9; step(1);
        chk("R5 release", int'(led_out), 6);
    endtask

    task automatic t_gpo;
        led_sel = 16'h0000; pin1_gpo_mode = 1'b1; pin1_gpo_level = 1'b0; step(1);
        chk("R8 gpo low out", int'(led_out[1]), 0);
        chk("R8 gpo oe", int'(led_oe), 2);
        pin1_gpo_level = 1'b1; led_sel = 16'h0CA9; link_speed = 2'd1; step(1);
        chk("R8 gpo high over LED1", int'(led_out[1]), 1);
        pin1_gpo_mode = 1'b0; step(1);
        chk("R8 back to LED1", int'(led_out[1]), 0);
        link_speed = 2'd0; step(1);
    endtask

    task automatic t_blink(input logic [7:0] cfg, input string tag);
        int per;
        int lowc;
        blink_cfg = cfg; led_sel = 16'h0009; link_up = 1'b1; link_speed = 2'd0;
        act_pulse = 1'b1;
        measure(per, lowc);
        measure(per, lowc);
        chk({tag, " period"}, per, exp_period(cfg) * CYC_PER_MS);
        chk({tag, " lit"}, lowc, exp_on_ms(cfg) * CYC_PER_MS);
    endtask

    task automatic t_stretch;
        int dark;
        blink_cfg = 8'h0B; led_sel = 16'h0009; link_up = 1'b1; link_speed = 2'd0;
        act_pulse = 1'b0;
        step(3 * 320 + 10);
        dark = 0;
        for (int k = 0; k < 400; k++) begin
            step(1);
            if (led_out[0]) dark++;
        end
        chk("R3 no activity no blink", dark, 0);
        act_pulse = 1'b1; step(1); act_pulse = 1'b0;
        dark = 0;
        for (int k = 0; k < 1000; k++) begin
            step(1);
            if (led_out[0]) dark++;
        end
        chk("R7 single pulse one off window", dark, 20 * CYC_PER_MS);
        led_sel = 16'h0001; act_pulse = 1'b1;
        dark = 0;
        for (int k = 0; k < 700; k++) begin
            step(1);
            if (led_out[0]) dark++;
        end
        chk("R3 blink bit clear steady", dark, 0);
        act_pulse = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(4);
        t_reset();
        rst = 1'b0;
        t_speed();
        t_off_and_pd();
        t_gpo();
        t_blink(8'h0B, "R6 code 0x0B");
        t_blink(8'h1B, "R6 half duty");
        t_blink(8'h05, "R6 period 50ms");
        t_blink(8'h3F, "R6 7/8 duty");
        t_blink(8'hCB, "R6 top bits no effect");
        t_blink(8'h20, "R10 quarter duty short period");
        t_stretch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule